// File: doc/BRIEF.md
# Load/Store Word Size Aligner

This block carries out the two single-word descriptor commands of a descriptor-driven DMA engine: a load that reads 1, 2 or 4 bytes from system memory into the descriptor's 32-bit command-dependent word, and a store that writes 1, 2 or 4 bytes taken from that word out to memory. The engine hands over one command at a time (direction, key, the low three bits of the request count, a byte address and the current command-dependent word). The block works out the access size, aligns the address, runs one byte-enabled access on a little-endian 32-bit memory port and returns either a one-cycle `done` with the updated word or a one-cycle `kill` when the key names an address space the block cannot reach.

The control is a four-state machine. IDLE accepts a command (`cmd_ready` high) and moves on IDLE->ACCESS for a legal key or IDLE->KILL for an illegal one. ACCESS holds the memory request until `mem_ack`, then ACCESS->DONE. DONE pulses `done` for one cycle and DONE->IDLE follows. KILL pulses `kill` for one cycle and KILL->IDLE follows.

Top module: `lsw_aligner`

## Requirements
- R1: The access size comes from the 3-bit count alone: bit 2 set gives 4 bytes; else bit 1 set gives 2 bytes; else 1 byte.
- R2: The memory address is the command address with bits [1:0] cleared for 4 bytes, bit 0 cleared for 2 bytes, and unchanged for 1 byte.
- R3: Byte enables are little-endian: bit n of `mem_be` enables data bits [8n+7:8n]; the enabled lanes are the size's bytes starting at lane address[1:0] of the aligned address.
- R4: Keys 0 to 4 are treated as key 6 (system memory); after that, key 6 is legal and keys 5 and 7 are illegal.
- R5: An illegal key gives exactly one `kill` cycle in the cycle after acceptance, with no memory request and no `done`.
- R6: A load returns the read bytes left-justified: 4 bytes give the read word; 2 bytes give data<<16 with the old low 16 bits kept; 1 byte gives data<<24 with the old low 24 bits kept.
- R7: A store writes the command-dependent word shifted right by 0, 16 or 24 for sizes 4, 2, 1, placed on the enabled lanes; `result` then equals the unchanged word.
- R8: `mem_req` stays high with stable address, enables and direction until `mem_ack` is sampled; `done` rises in the cycle after that and lasts one cycle.
- R9: After reset and between commands the block is in IDLE: `cmd_ready` high, no `mem_req`, `done` or `kill`; a command is taken only when `cmd_valid` and `cmd_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_is_store | input | 1 | 1 = store, 0 = load |
| cmd_key | input | 3 | Address-space key |
| cmd_cnt | input | 3 | Low three bits of the request count |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_dep | input | 32 | Command-dependent word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | ADDR_W | Aligned byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data on lanes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| done | output | 1 | Command finished |
| kill | output | 1 | Illegal key, command dropped |
| result | output | 32 | Updated command-dependent word with done |

## Verification
The assertions take for granted that the memory side raises `mem_ack` only while `mem_req` is high, presents `mem_rdata` in that same cycle and drops `mem_ack` after one cycle. The bench answers each request after zero to two wait cycles and lowers the acknowledge straight after the transfer edge, so it never acknowledges an idle port. Commands are presented only with `cmd_ready` high and are withdrawn one cycle later, which matches the block's single-command acceptance.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    localparam logic [2:0] KEY_REGSPACE = 3'd5;
    localparam logic [2:0] KEY_SYSMEM   = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_DONE,
        ST_KILL
    } lsw_state_e;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2
    } lsw_size_e;
endpackage

// File: rtl/lsw_key_check.sv
module lsw_key_check
    import lsw_pkg::*;
(
    input  logic [2:0] key,
    output logic       legal
);
    logic [2:0] resolved;

    always_comb begin
        resolved = (key < KEY_REGSPACE) ? KEY_SYSMEM : key;
        legal    = (resolved == KEY_SYSMEM);
    end
endmodule

// File: rtl/lsw_size_decode.sv
module lsw_size_decode
    import lsw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        cnt,
    input  logic [ADDR_W-1:0] addr_in,
    output lsw_size_e         size,
    output logic [ADDR_W-1:0] addr_al,
    output logic [LANES-1:0]  be
);
    always_comb begin
        if (cnt[2]) begin
            size    = SZ_4;
            addr_al = {addr_in[ADDR_W-1:2], 2'b00};
            be      = 4'b1111;
        end else if (cnt[1]) begin
            size    = SZ_2;
            addr_al = {addr_in[ADDR_W-1:1], 1'b0};
            be      = addr_in[1] ? 4'b1100 : 4'b0011;
        end else begin
            size    = SZ_1;
            addr_al = addr_in;
            be      = 4'b0001 << addr_in[1:0];
        end
    end
endmodule

// File: rtl/lsw_lane_path.sv
module lsw_lane_path
    import lsw_pkg::*;
(
    input  lsw_size_e         size,
    input  logic [1:0]        lane,
    input  logic [WORD_W-1:0] dep,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] load_val
);
    logic [WORD_W-1:0] store_val;
    logic [WORD_W-1:0] rd_shift;

    always_comb begin
        unique case (size)
            SZ_4:    store_val = dep;
            SZ_2:    store_val = {16'h0000, dep[31:16]};
            default: store_val = {24'h000000, dep[31:24]};
        endcase
        wdata    = store_val << {lane, 3'b000};
        rd_shift = rdata >> {lane, 3'b000};
        unique case (size)
            SZ_4:    load_val = rdata;
            SZ_2:    load_val = {rd_shift[15:0], dep[15:0]};
            default: load_val = {rd_shift[7:0], dep[23:0]};
        endcase
    end
endmodule

// File: rtl/lsw_aligner.sv
module lsw_aligner
    import lsw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_is_store,
    input  logic [2:0]        cmd_key,
    input  logic [2:0]        cmd_cnt,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [31:0]       cmd_dep,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic              kill,
    output logic [31:0]       result
);
    lsw_state_e        state_q, state_d;
    logic              key_ok;
    lsw_size_e         size_d, size_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [LANES-1:0]  be_d, be_q;
    logic              store_q;
    logic [WORD_W-1:0] dep_q, result_q;
    logic [WORD_W-1:0] wdata_w, load_w;
    logic              accept;

    lsw_key_check u_key (
        .key   (cmd_key),
        .legal (key_ok)
    );

    lsw_size_decode #(.ADDR_W(ADDR_W)) u_size (
        .cnt     (cmd_cnt),
        .addr_in (cmd_addr),
        .size    (size_d),
        .addr_al (addr_d),
        .be      (be_d)
    );

    lsw_lane_path u_lane (
        .size     (size_q),
        .lane     (addr_q[1:0]),
        .dep      (dep_q),
        .rdata    (mem_rdata),
        .wdata    (wdata_w),
        .load_val (load_w)
    );

    assign accept = cmd_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = key_ok ? ST_ACCESS : ST_KILL;
            ST_ACCESS: if (mem_ack)   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_KILL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q   <= SZ_1;
            addr_q   <= '0;
            be_q     <= '0;
            store_q  <= 1'b0;
            dep_q    <= '0;
            result_q <= '0;
        end else if (accept) begin
            size_q   <= size_d;
            addr_q   <= addr_d;
            be_q     <= be_d;
            store_q  <= cmd_is_store;
            dep_q    <= cmd_dep;
            result_q <= cmd_dep;
        end else if (state_q == ST_ACCESS && mem_ack) begin
            result_q <= store_q ? dep_q : load_w;
        end
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '0;
        done      = 1'b0;
        kill      = 1'b0;
        unique case (state_q)
            ST_IDLE:   cmd_ready = 1'b1;
            ST_ACCESS: begin
                mem_req = 1'b1;
                mem_we  = store_q;
                mem_be  = be_q;
            end
            ST_DONE:   done = 1'b1;
            ST_KILL:   kill = 1'b1;
            default:   cmd_ready = 1'b0;
        endcase
        mem_addr  = addr_q;
        mem_wdata = wdata_w;
        result    = result_q;
    end
endmodule

// File: rtl/lsw_aligner_chk.sv
module lsw_aligner_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_key,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              mem_ack,
    input logic              done,
    input logic              kill
);
    assert_align4_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $countones(mem_be) == 4) |-> (mem_addr[1:0] == 2'b00));

    assert_align2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $countones(mem_be) == 2) |-> (mem_addr[0] == 1'b0));

    assert_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be[mem_addr[1:0]] &&
                     ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                      $countones(mem_be) == 4)));

    assert_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_key == 3'd5 || cmd_key == 3'd7)) |=> kill);

    assert_kill_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> (!mem_req && !done));

    assert_kill_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !kill);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_be) && $stable(mem_we)));

    assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (done && !mem_req));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_req && !done && !kill));
endmodule

bind lsw_aligner lsw_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_key   (cmd_key),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_ack   (mem_ack),
    .done      (done),
    .kill      (kill)
);

// File: tb/lsw_aligner_tb.sv
module lsw_aligner_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_ready, cmd_is_store;
    logic [2:0]  cmd_key, cmd_cnt;
    logic [31:0] cmd_addr, cmd_dep;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        done, kill;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lsw_aligner u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_store(cmd_is_store),
        .cmd_key(cmd_key), .cmd_cnt(cmd_cnt), .cmd_addr(cmd_addr), .cmd_dep(cmd_dep),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done(done), .kill(kill), .result(result)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit st, input logic [2:0] key, input logic [2:0] cnt,
                          input logic [31:0] addr, input logic [31:0] dep,
                          input logic [31:0] rd, input int waits);
        int          size;
        bit          legal;
        logic [31:0] aaddr, bemask, val, exp_res, data;
        logic [3:0]  exp_be;
        int          lo;
        size  = cnt[2] ? 4 : (cnt[1] ? 2 : 1);
        legal = (key < 3'd5) || (key == 3'd6);
        aaddr = addr & ~(32'(size) - 32'd1);
        lo    = int'(aaddr[1:0]);
        exp_be = 4'(((1 << size) - 1) << lo);
        bemask = 32'h0;
        for (int i = 0; i < 4; i++) if (exp_be[i]) bemask[i*8 +: 8] = 8'hFF;

        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_store = st; cmd_key = key; cmd_cnt = cnt;
        cmd_addr = addr; cmd_dep = dep;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!legal) begin
            chk(kill === 1'b1 && mem_req === 1'b0 && done === 1'b0, "R4/R5 kill pulse",
                {29'd0, kill, mem_req, done}, 32'h4);
            @(negedge clk);
            chk(kill === 1'b0 && cmd_ready === 1'b1, "R5 single kill cycle",
                {30'd0, kill, cmd_ready}, 32'h1);
            return;
        end
        chk(mem_req === 1'b1 && mem_we === st, "R4 legal key issues access",
            {30'd0, mem_req, mem_we}, {30'd0, 1'b1, st});
        chk(mem_addr === aaddr, "R1/R2 aligned address", mem_addr, aaddr);
        chk(mem_be === exp_be, "R1/R3 byte enables", {28'd0, mem_be}, {28'd0, exp_be});
        if (st) begin
            val = (size == 4) ? dep : ((size == 2) ? (dep >> 16) : (dep >> 24));
            val = (val << (8 * lo)) & bemask;
            chk((mem_wdata & bemask) === val, "R7 store lanes", mem_wdata & bemask, val);
        end
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            chk(mem_req === 1'b1 && done === 1'b0 && mem_addr === aaddr,
                "R8 request held", {31'd0, mem_req}, 32'h1);
        end
        mem_ack = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 32'hDEADBEEF;
        if (st) exp_res = dep;
        else begin
            data = rd >> (8 * lo);
            if (size == 4)      exp_res = rd;
            else if (size == 2) exp_res = (data << 16) | (dep & 32'h0000FFFF);
            else                exp_res = (data << 24) | (dep & 32'h00FFFFFF);
        end
        chk(done === 1'b1 && mem_req === 1'b0, "R8 done after ack",
            {30'd0, done, mem_req}, 32'h2);
        chk(result === exp_res, st ? "R7 store result" : "R6 load merge", result, exp_res);
        @(negedge clk);
        chk(done === 1'b0 && cmd_ready === 1'b1, "R9 back to idle",
            {30'd0, done, cmd_ready}, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_is_store = 1'b0; cmd_key = 3'd0;
        cmd_cnt = 3'd0; cmd_addr = 32'd0; cmd_dep = 32'd0;
        mem_ack = 1'b0; mem_rdata = 32'd0;
        repeat (3) @(negedge clk);
        chk(cmd_ready === 1'b1 && mem_req === 1'b0 && done === 1'b0 && kill === 1'b0,
            "R9 reset state", {28'd0, cmd_ready, mem_req, done, kill}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: command absent, nothing happens
        repeat (2) @(negedge clk);
        chk(cmd_ready === 1'b1 && mem_req === 1'b0, "R9 idle without valid",
            {30'd0, cmd_ready, mem_req}, 32'h2);
        for (int st = 0; st < 2; st++)
            for (int k = 0; k < 8; k++)
                for (int c = 0; c < 8; c++)
                    for (int lo = 0; lo < 4; lo++) begin
                        int op;
                        op = ((st * 8 + k) * 8 + c) * 4 + lo;
                        run_op(st[0], 3'(k), 3'(c),
                               {30'(32'h1234_5670 + op * 64) , 2'(lo)},
                               32'h5E6F7081 ^ (32'(op) * 32'h01030507),
                               32'hA1B2C3D4 ^ (32'(op) * 32'h0F0E0D0B),
                               (c + lo) % 3);
                    end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule